// File: doc/BRIEF.md
# Serial Flash Bulk-Erase Command Controller

This block is the slave-side command logic of a serial flash device. It covers three things: the write-enable latch, the whole-array erase command and status-register reads. It samples SPI mode 0 traffic, with data taken on the rising SCK edge, MSB first, while chip select is held low. It decodes 8-bit opcodes. Write enable is `0x06`, status read is `0x05` and bulk erase is `0xC7`.

A bulk erase runs only if four conditions hold. A previous frame must have set the write-enable latch. Both block-protect bits must be 0. Chip select must rise with SCK low right after the eighth opcode bit. No erase may already be running. When an erase is accepted, the block starts a self-timed cycle. The cycle asks the array, through a request/done handshake, to drive every bit to 1. It lasts a programmable number of system clocks. While the cycle runs, only status reads are served. SCK, chip select and serial input reach the system clock domain through two-flop synchronizers, and all edge detection happens after them.

Top module: `flash_erase_ctrl`

## Requirements
- R1: A frame that holds exactly 8 bits of opcode `0x06` and ends with chip select rising while SCK is low sets the write-enable latch, provided no erase is running.
- R2: A frame that holds exactly 8 bits of opcode `0xC7` starts an erase when the latch is set and `prot_bp` is `00`. The erase sets the busy bit and raises `clr_req` until `clr_done` is seen. Afterwards the whole array reads as all ones.
- R3: A bulk-erase frame sent while the latch is clear is ignored: no `clr_req`, and busy stays 0.
- R4: A bulk-erase frame sent while either protect bit is 1 is ignored, and the latch keeps its value.
- R5: A frame whose chip select rises after 7 or after 9 clocked bits runs nothing, whatever its opcode.
- R6: Opcode `0x05` returns the status byte MSB first on `spi_so`, changed on SCK falling edges. The byte is laid out as bit 0 = busy, bit 1 = write-enable latch, bits 3:2 = `prot_bp[1:0]`, bits 7:4 = 0. The byte repeats for as long as SCK keeps toggling.
- R7: While an erase runs, status reads still work, and any further erase or write-enable frame is ignored.
- R8: Busy stays 1 for at least `ERASE_CLKS` system clocks and until `clr_done` has arrived. The latch clears one clock before busy falls, so the block then reads as idle with the latch clear.
- R9: After reset the status byte shows busy 0 and latch 0, and `clr_req` is 0.
- R10: `spi_so` is driven 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data into the device |
| spi_so | output | 1 | Serial data out of the device |
| prot_bp | input | 2 | Block-protect level; any nonzero value forbids erase |
| clr_req | output | 1 | Request to the array to set every bit to 1 |
| clr_done | input | 1 | Array acknowledges that the clear is complete |

## Verification
The bench targets frames whose chip select rises one bit early or one bit late. A design that counted loosely would then set the latch or erase on a truncated or over-long frame. It sends an erase frame in the middle of a running erase. A design without the lockout would raise a second array request. It withholds `clr_done` past the programmed duration, which would expose a timer that drops busy before the array confirms. It sends erase attempts with the latch clear or with a protect bit set, to catch a missing qualifier. Random frame sequences with random protect levels are checked against a status model kept in the bench.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam int OP_BITS = 8;
  localparam int CNT_W   = $clog2(OP_BITS);

  localparam logic [OP_BITS-1:0] OP_WREN = 8'h06;
  localparam logic [OP_BITS-1:0] OP_RDSR = 8'h05;
  localparam logic [OP_BITS-1:0] OP_BULK = 8'hC7;

  // where a frame stands after its last SCK rise
  typedef enum logic [1:0] {
    M_OPCODE,   // collecting opcode bits
    M_HELD,     // exactly one opcode byte in, waiting for chip select
    M_STATUS,   // streaming the status byte
    M_DROP      // frame over-long or not executable
  } frame_mode_e;

  typedef enum logic [1:0] {
    T_IDLE,
    T_RUN,
    T_WRAP
  } tmr_state_e;
endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
  parameter int             STAGES  = 2,
  parameter int             WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fe_cmd_decode.sv
module fe_cmd_decode
  import flash_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sck_s,
  input  logic       cs_s,      // synchronized chip select, 1 = deselected
  input  logic       si_s,
  input  logic       busy,
  input  logic       wel_clear,
  input  logic [1:0] bp,
  output logic       wel,
  output logic       start,
  output logic       so
);
  logic                 sck_d, cs_d;
  logic                 sck_rise, sck_fall, cs_rise;
  logic [CNT_W-1:0]     bit_cnt;
  logic [OP_BITS-1:0]   sh;
  logic [OP_BITS-1:0]   sh_next;
  frame_mode_e          mode;
  logic [2:0]           out_idx;
  logic [7:0]           snap;
  logic [7:0]           status_now;
  logic                 held_ok;
  logic                 wel_q, so_q;

  assign sck_rise   = sck_s & ~sck_d;
  assign sck_fall   = ~sck_s & sck_d;
  assign cs_rise    = cs_s & ~cs_d;
  assign sh_next    = {sh[OP_BITS-2:0], si_s};
  assign status_now = {4'b0000, bp, wel_q, busy};

  // chip select rose with SCK low, right after a whole opcode byte
  assign held_ok = cs_rise && (mode == M_HELD) && !sck_s && !busy;
  assign start   = held_ok && (sh == OP_BULK) && wel_q && (bp == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d   <= 1'b0;
      cs_d    <= 1'b1;
      bit_cnt <= '0;
      sh      <= '0;
      mode    <= M_OPCODE;
      out_idx <= '0;
      snap    <= '0;
      wel_q   <= 1'b0;
      so_q    <= 1'b0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;

      if (wel_clear)                      wel_q <= 1'b0;
      else if (held_ok && sh == OP_WREN)  wel_q <= 1'b1;

      if (cs_s) begin
        mode    <= M_OPCODE;
        bit_cnt <= '0;
        out_idx <= '0;
        so_q    <= 1'b0;
      end else begin
        if (sck_rise) begin
          unique case (mode)
            M_OPCODE: begin
              sh      <= sh_next;
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == CNT_W'(OP_BITS-1))
                mode <= (sh_next == OP_RDSR) ? M_STATUS : M_HELD;
            end
            M_HELD:   mode <= M_DROP;
            default:  ;
          endcase
        end
        if (sck_fall && mode == M_STATUS) begin
          if (out_idx == 3'd0) begin
            snap <= status_now;
            so_q <= status_now[7];
          end else begin
            so_q <= snap[3'd7 - out_idx];
          end
          out_idx <= out_idx + 1'b1;
        end
      end
    end
  end

  assign wel = wel_q;
  assign so  = so_q;
endmodule

// File: rtl/fe_erase_timer.sv
module fe_erase_timer
  import flash_erase_pkg::*;
#(
  parameter int ERASE_CLKS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic clr_done,
  output logic busy,
  output logic clr_req,
  output logic wel_clear
);
  localparam int CW = $clog2(ERASE_CLKS + 1);

  tmr_state_e    st;
  logic [CW-1:0] cnt;
  logic          acked;
  logic          req_q;
  logic          ack_ok;

  assign ack_ok    = acked | (req_q & clr_done);
  assign wel_clear = (st == T_RUN) && (cnt == '0) && ack_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= T_IDLE;
      cnt   <= '0;
      acked <= 1'b0;
      req_q <= 1'b0;
    end else begin
      unique case (st)
        T_IDLE: if (start) begin
          st    <= T_RUN;
          cnt   <= CW'(ERASE_CLKS - 1);
          req_q <= 1'b1;
          acked <= 1'b0;
        end
        T_RUN: begin
          if (req_q && clr_done) begin
            req_q <= 1'b0;
            acked <= 1'b1;
          end
          if (cnt != '0) cnt <= cnt - 1'b1;
          if (wel_clear) st <= T_WRAP;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assign busy    = (st != T_IDLE);
  assign clr_req = req_q;
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl #(
  parameter int ERASE_CLKS  = 2000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_si,
  output logic       spi_so,
  input  logic [1:0] prot_bp,
  output logic       clr_req,
  input  logic       clr_done
);
  logic [2:0] pins_s;
  logic       cs_s, sck_s, si_s;
  logic       busy, wel, start, wel_clear;

  fe_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({spi_cs_n, spi_sck, spi_si}),
    .q  (pins_s)
  );

  assign cs_s  = pins_s[2];
  assign sck_s = pins_s[1];
  assign si_s  = pins_s[0];

  fe_cmd_decode u_dec (
    .clk      (clk),
    .rst      (rst),
    .sck_s    (sck_s),
    .cs_s     (cs_s),
    .si_s     (si_s),
    .busy     (busy),
    .wel_clear(wel_clear),
    .bp       (prot_bp),
    .wel      (wel),
    .start    (start),
    .so       (spi_so)
  );

  fe_erase_timer #(
    .ERASE_CLKS(ERASE_CLKS)
  ) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .clr_done (clr_done),
    .busy     (busy),
    .clr_req  (clr_req),
    .wel_clear(wel_clear)
  );
endmodule

// File: rtl/fe_checker.sv
module fe_checker #(
  parameter int ERASE_CLKS = 2000000
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       wel,
  input logic       clr_req,
  input logic       cs_s,
  input logic       spi_so,
  input logic [1:0] prot_bp
);
  logic [31:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst)       busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= '0;
  end

  // R2
  erase_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(wel) && $past(prot_bp) == 2'b00));

  // R2
  req_within_busy_chk: assert property (@(posedge clk) disable iff (rst)
    clr_req |-> busy);

  // R8
  latch_clears_first_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !$past(wel));

  // R8
  erase_length_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len >= 32'(ERASE_CLKS)));

  // R10
  so_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !spi_so);
endmodule

bind flash_erase_ctrl fe_checker #(.ERASE_CLKS(ERASE_CLKS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .wel    (wel),
  .clr_req(clr_req),
  .cs_s   (cs_s),
  .spi_so (spi_so),
  .prot_bp(prot_bp)
);

// File: tb/flash_erase_ctrl_bench.sv
`timescale 1ns/1ps
module flash_erase_ctrl_bench;
  localparam int E  = 600;
  localparam int HP = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, clr_req, clr_done;
  logic [1:0] bp = 2'b00;
  int nvec = 0, nfail = 0, erase_cnt = 0, ack_dly = 5;
  logic [7:0] arr [16];

  always #2 clk = ~clk;

  flash_erase_ctrl #(.ERASE_CLKS(E)) u_flash_erase_ctrl (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_so(so), .prot_bp(bp), .clr_req(clr_req), .clr_done(clr_done)
  );

  // array model: acknowledges each clear request and fills itself with ones
  initial begin
    clr_done = 1'b0;
    for (int i = 0; i < 16; i++) arr[i] = 8'h00;
    forever begin
      wait (clr_req === 1'b1);
      erase_cnt++;
      repeat (ack_dly) @(negedge clk);
      for (int i = 0; i < 16; i++) arr[i] = 8'hFF;
      clr_done = 1'b1;
      @(negedge clk);
      clr_done = 1'b0;
      wait (clr_req === 1'b0);
    end
  end

  function automatic logic [7:0] st_exp(logic [1:0] b, logic w, logic bz);
    return {4'b0000, b, w, bz};
  endfunction

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] op, input int nbits, input int nrd,
                      output logic [15:0] rd);
    rd = '0;
    cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      si = op[7 - (i % 8)];
      repeat (HP) @(negedge clk);
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
    for (int i = 0; i < nrd * 8; i++) begin
      repeat (HP) @(negedge clk);
      rd = {rd[14:0], so};
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [15:0] r;
    xfer(8'h05, 8, 1, r);
    v = r[7:0];
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int k = 0; k < 200; k++) begin
      rdsr(v);
      if (!v[0]) break;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    logic [7:0]  v, op;
    logic        wel_m;
    int          nb, ec;
    void'($urandom(32'd1357));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R9 / R10 reset state
    chk("R9 clr_req after reset", {15'd0, clr_req}, 16'd0);
    chk("R10 so while deselected", {15'd0, so}, 16'd0);

    // R6 two repeated status bytes with protect level 10
    bp = 2'b10;
    xfer(8'h05, 8, 2, r);
    chk("R6 R9 repeated status", r, {st_exp(2'b10, 0, 0), st_exp(2'b10, 0, 0)});
    bp = 2'b00;

    // R3 erase with latch clear
    xfer(8'hC7, 8, 0, r);
    chk("R3 no erase without latch", erase_cnt[15:0], 16'd0);
    rdsr(v); chk("R3 status", {8'd0, v}, {8'd0, st_exp(2'b00, 0, 0)});

    // R5 short and long write-enable frames
    xfer(8'h06, 7, 0, r);
    rdsr(v); chk("R5 7-bit WREN", {8'd0, v}, {8'd0, st_exp(2'b00, 0, 0)});
    xfer(8'h06, 9, 0, r);
    rdsr(v); chk("R5 9-bit WREN", {8'd0, v}, {8'd0, st_exp(2'b00, 0, 0)});

    // R1
    xfer(8'h06, 8, 0, r);
    rdsr(v); chk("R1 latch set", {8'd0, v}, {8'd0, st_exp(2'b00, 1, 0)});

    // R4 protect bit set
    bp = 2'b01;
    xfer(8'hC7, 8, 0, r);
    chk("R4 no erase when protected", erase_cnt[15:0], 16'd0);
    rdsr(v); chk("R4 latch kept", {8'd0, v}, {8'd0, st_exp(2'b01, 1, 0)});
    bp = 2'b00;

    // R5 short and long erase frames
    xfer(8'hC7, 7, 0, r);
    xfer(8'hC7, 9, 0, r);
    chk("R5 no erase on 7/9 bits", erase_cnt[15:0], 16'd0);

    // R2 accepted erase, R7 lockout while busy
    ack_dly = 5;
    xfer(8'hC7, 8, 0, r);
    chk("R2 erase requested", erase_cnt[15:0], 16'd1);
    rdsr(v); chk("R7 R6 status while busy", {8'd0, v}, {8'd0, st_exp(2'b00, 1, 1)});
    xfer(8'hC7, 8, 0, r);
    wait_idle();
    rdsr(v); chk("R8 idle with latch clear", {8'd0, v}, {8'd0, st_exp(2'b00, 0, 0)});
    chk("R7 no second erase", erase_cnt[15:0], 16'd1);
    chk("R2 array all ones", {8'd0, arr[0] & arr[15]}, 16'h00FF);

    // R8 late acknowledge holds busy past the timer
    ack_dly = 1000;
    xfer(8'h06, 8, 0, r);
    xfer(8'hC7, 8, 0, r);
    repeat (E + 50) @(negedge clk);
    rdsr(v); chk("R8 busy until done", {8'd0, v}, {8'd0, st_exp(2'b00, 1, 1)});
    wait_idle();
    rdsr(v); chk("R8 idle after late ack", {8'd0, v}, {8'd0, st_exp(2'b00, 0, 0)});

    // random frames against a status model (R1 R3 R4 R5 R6)
    wel_m = 1'b0;
    for (int n = 0; n < 40; n++) begin
      ec = erase_cnt;
      bp = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
      case ($urandom % 4)
        0: op = 8'h06;
        1: op = 8'hC7;
        2: op = 8'h05;
        default: op = 8'($urandom);
      endcase
      case ($urandom % 5)
        0: nb = 7;
        1: nb = 9;
        default: nb = 8;
      endcase
      ack_dly = 1 + int'($urandom % 40);
      if (op == 8'h05) begin
        xfer(op, 8, 1, r);
        chk("R6 random status", {8'd0, r[7:0]}, {8'd0, st_exp(bp, wel_m, 0)});
      end else begin
        xfer(op, nb, 0, r);
        if (nb == 8 && op == 8'hC7 && wel_m && bp == 2'b00) begin
          chk("R2 random erase", erase_cnt[15:0], 16'(ec + 1));
          wait_idle();
          wel_m = 1'b0;
        end else begin
          if (nb == 8 && op == 8'h06) wel_m = 1'b1;
          chk("R3 R4 R5 random no erase", erase_cnt[15:0], 16'(ec));
        end
        rdsr(v);
        chk("R1 random status", {8'd0, v}, {8'd0, st_exp(bp, wel_m, 0)});
      end
    end
    finish_run();
  end
endmodule